// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry input. It returns a 16-bit sum and a carry output. It is purely combinational. It has no clock, no reset and no registers.

Each bit position forms two terms: generate (both operand bits set) and propagate (either operand bit set). The operand is split into four groups of four bits. Each group uses flat sum-of-products logic to form the carries inside the group from its own terms and its carry-in. Each group also reports a group generate and a group propagate. A second lookahead stage applies the same flat expansion to those group terms and produces the carry into every group together with the final carry-out. No carry ever ripples from one group to the next. Each sum bit is the XOR of the two operand bits and the carry into that bit.

The width and the group size are parameters. A designer can place the adder wherever a single-cycle add with a short carry path is needed, and registers any result outside the block.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `op_a + op_b + carry_in`, for every operand value and both carry-in values.
- R2: `carry_out` equals bit 16 of the 17-bit result of `op_a + op_b + carry_in`.
- R3: When `op_a + op_b` is 0xFFFF and `carry_in` is 1, the carry crosses all four groups: `sum_o` is 0x0000 and `carry_out` is 1. When `carry_in` is 0 with the same operands, `sum_o` is 0xFFFF and `carry_out` is 0.
- R4: A carry generated in bit 0, with every higher bit in propagate-only state (operand bits differ), reaches the output: `sum_o` is 0x0000 and `carry_out` is 1.
- R5: With both operands zero, `sum_o` is 0 and `carry_out` is 0 when `carry_in` is 0. The result is `sum_o` = 0x0001 and `carry_out` = 0 when `carry_in` is 1. Two all-ones operands with `carry_in` 1 give 0xFFFF and a carry-out of 1.
- R6: The carry entering group k (bits 4k to 4k+3) equals the carry out of the arithmetic sum of the operand bits below bit 4k plus `carry_in`.
- R7: A group's generate term is 1 exactly when the sum of its two 4-bit operand slices exceeds 15, that is, when the group produces a carry with no carry entering it.
- R8: A group whose two 4-bit operand slices add to exactly 15 passes its entering carry to the next group unchanged, and its group propagate term is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The bound checker checks at every input change that the sum and the carry-out match integer addition. It also checks that every group-entry carry from the second stage matches the arithmetic carry of the bits below it. For each group it checks that the generate and propagate terms agree with the operand slices. Whether a carry really crosses a group boundary, whether a propagate-only group passes a carry through, and whether the long all-propagate chain gives the right result can only be shown by the bench scenarios. The bench sweeps every slice pair of every group with controlled carries, then runs boundary patterns and a long pseudo-random run.

// File: rtl/lka_pkg.sv
// Package lka_pkg
// Shared constants and the flat lookahead carry function.
// Assumes: no lookahead span wider than LKA_MAXW terms.
package lka_pkg;

    localparam int LKA_MAXW = 32;

    // Carry out of the lowest n positions of a generate/propagate span
    // with carry c0 entering position 0. The loop unrolls into a flat
    // OR of AND terms, so depth does not grow with position.
    function automatic logic span_carry(
        input logic [LKA_MAXW-1:0] gen_v,
        input logic [LKA_MAXW-1:0] prop_v,
        input logic                c0,
        input int                  n
    );
        logic acc;
        logic run;
        acc = 1'b0;
        run = 1'b1;
        for (int j = LKA_MAXW - 1; j >= 0; j--) begin
            if (j < n) begin
                acc = acc | (run & gen_v[j]);
                run = run & prop_v[j];
            end
        end
        return acc | (run & c0);
    endfunction

endpackage

// File: rtl/lka_bit_pg.sv
// Module lka_bit_pg
// Forms the generate and propagate term of every bit position.
// Assumes: propagate is the inclusive OR, so the sum is formed
// from the operands directly and not from propagate.
module lka_bit_pg #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] bit_gen,
    output logic [WIDTH-1:0] bit_prop
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // One generate/propagate pair per bit
        assign bit_gen[i]  = op_a[i] & op_b[i];
        assign bit_prop[i] = op_a[i] | op_b[i];
    end

endmodule

// File: rtl/lka_group.sv
// Module lka_group
// First lookahead level. Carries into each bit of one group and the
// group generate/propagate pair.
// Assumes: GW <= LKA_MAXW.
module lka_group
    import lka_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] bit_gen,
    input  logic [GW-1:0] bit_prop,
    input  logic          grp_cin,
    output logic [GW-1:0] bit_cin,
    output logic          grp_gen,
    output logic          grp_prop
);

    // Expanded carry into each bit, from the terms and the group carry-in only
    always_comb begin
        for (int k = 0; k < GW; k++) begin
            bit_cin[k] = span_carry(LKA_MAXW'(bit_gen), LKA_MAXW'(bit_prop),
                                    grp_cin, k);
        end
    end

    // Group generate: carry out of the whole group with no carry entering
    assign grp_gen  = span_carry(LKA_MAXW'(bit_gen), LKA_MAXW'(bit_prop),
                                 1'b0, GW);
    // Group propagate: every bit of the group propagates
    assign grp_prop = &bit_prop;

endmodule

// File: rtl/lka_level2.sv
// Module lka_level2
// Second lookahead level. Applies the same expansion to the group terms
// and returns the carry into each group and the final carry-out.
// Assumes: NG <= LKA_MAXW.
module lka_level2
    import lka_pkg::*;
#(
    parameter int NG = 4
) (
    input  logic [NG-1:0] grp_gen,
    input  logic [NG-1:0] grp_prop,
    input  logic          carry_in,
    output logic [NG-1:0] grp_cin,
    output logic          carry_out
);

    // Carry into each group, flat in the group terms and carry_in
    always_comb begin
        for (int k = 0; k < NG; k++) begin
            grp_cin[k] = span_carry(LKA_MAXW'(grp_gen), LKA_MAXW'(grp_prop),
                                    carry_in, k);
        end
    end

    // Carry out of the top group
    assign carry_out = span_carry(LKA_MAXW'(grp_gen), LKA_MAXW'(grp_prop),
                                  carry_in, NG);

endmodule

// File: rtl/lka_sum_xor.sv
// Module lka_sum_xor
// Sum bits from the operands and the carry into each bit.
// Assumes: the carries are final (both lookahead levels resolved).
module lka_sum_xor #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] bit_cin,
    output logic [WIDTH-1:0] sum_o
);

    // Three-input XOR per bit
    assign sum_o = op_a ^ op_b ^ bit_cin;

endmodule

// File: rtl/lookahead_adder.sv
// Module lookahead_adder
// Top of the two-level carry-lookahead adder. Per-bit terms feed GROUP-bit
// lookahead groups, and the group terms feed a second lookahead level.
// Purely combinational.
// Assumes: WIDTH is a multiple of GROUP, and both GROUP and WIDTH/GROUP
// are at most lka_pkg::LKA_MAXW.
module lookahead_adder #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_out
);

    localparam int NG = WIDTH / GROUP;

    logic [WIDTH-1:0] bit_gen;
    logic [WIDTH-1:0] bit_prop;
    logic [WIDTH-1:0] bit_cin;
    logic [NG-1:0]    grp_gen;
    logic [NG-1:0]    grp_prop;
    logic [NG-1:0]    grp_cin;

    lka_bit_pg #(.WIDTH(WIDTH)) pg_i (
        .op_a     (op_a),
        .op_b     (op_b),
        .bit_gen  (bit_gen),
        .bit_prop (bit_prop)
    );

    for (genvar k = 0; k < NG; k++) begin : g_grp
        lka_group #(.GW(GROUP)) grp_i (
            .bit_gen  (bit_gen[k*GROUP +: GROUP]),
            .bit_prop (bit_prop[k*GROUP +: GROUP]),
            .grp_cin  (grp_cin[k]),
            .bit_cin  (bit_cin[k*GROUP +: GROUP]),
            .grp_gen  (grp_gen[k]),
            .grp_prop (grp_prop[k])
        );
    end

    lka_level2 #(.NG(NG)) lvl2_i (
        .grp_gen   (grp_gen),
        .grp_prop  (grp_prop),
        .carry_in  (carry_in),
        .grp_cin   (grp_cin),
        .carry_out (carry_out)
    );

    lka_sum_xor #(.WIDTH(WIDTH)) sum_i (
        .op_a    (op_a),
        .op_b    (op_b),
        .bit_cin (bit_cin),
        .sum_o   (sum_o)
    );

endmodule

// File: rtl/lookahead_adder_chk.sv
// Module lookahead_adder_chk
// Checker bound into lookahead_adder. Compares the ports and the
// second-level group signals with integer arithmetic on the operands.
// Assumes: combinational settling before each evaluation.
module lookahead_adder_chk #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input logic [WIDTH-1:0]       op_a,
    input logic [WIDTH-1:0]       op_b,
    input logic                   carry_in,
    input logic [WIDTH-1:0]       sum_o,
    input logic                   carry_out,
    input logic [WIDTH/GROUP-1:0] grp_gen,
    input logic [WIDTH/GROUP-1:0] grp_prop,
    input logic [WIDTH/GROUP-1:0] grp_cin
);

    localparam int NG = WIDTH / GROUP;
    localparam logic [GROUP:0] SLICE_MAX = {1'b0, {GROUP{1'b1}}};

    // Arithmetic carry into bit position lo_bits
    function automatic logic low_carry(input logic [WIDTH-1:0] a,
                                       input logic [WIDTH-1:0] b,
                                       input logic ci, input int lo_bits);
        logic [WIDTH:0] mask;
        logic [WIDTH:0] part;
        mask = ((WIDTH+1)'(1) << lo_bits) - (WIDTH+1)'(1);
        part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + (WIDTH+1)'(ci);
        return part[lo_bits];
    endfunction

    logic [WIDTH:0] full_sum;
    assign full_sum = {1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in);

    // Port-level result checks
    always_comb begin
        a_r1_sum_matches : assert (sum_o == full_sum[WIDTH-1:0])
            else $error("R1 sum %h expected %h", sum_o, full_sum[WIDTH-1:0]);
        a_r2_cout_matches : assert (carry_out == full_sum[WIDTH])
            else $error("R2 carry_out %b expected %b", carry_out, full_sum[WIDTH]);
    end

    // Group-level checks against slice arithmetic
    always_comb begin
        for (int k = 0; k < NG; k++) begin
            a_r6_group_entry_carry : assert (grp_cin[k] == low_carry(op_a, op_b, carry_in, k*GROUP))
                else $error("R6 group %0d entry carry wrong", k);
            a_r7_group_generate : assert (grp_gen[k] ==
                    (({1'b0, op_a[k*GROUP +: GROUP]} + {1'b0, op_b[k*GROUP +: GROUP]}) > SLICE_MAX))
                else $error("R7 group %0d generate wrong", k);
            a_r8_group_propagate : assert (!((op_a[k*GROUP +: GROUP] ^ op_b[k*GROUP +: GROUP]) == {GROUP{1'b1}})
                                           || grp_prop[k])
                else $error("R8 group %0d propagate missing", k);
        end
    end

endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) chk_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_o     (sum_o),
    .carry_out (carry_out),
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .grp_cin   (grp_cin)
);

// File: tb/lookahead_adder_tb_top.sv
// Bench lookahead_adder_tb_top
// Drives inputs after each rising edge and samples at the falling edge.
// Expected values come from integer addition in the bench.
module lookahead_adder_tb_top;

    localparam int WIDTH = 16;
    localparam int GROUP = 4;
    localparam int NG    = WIDTH / GROUP;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] op_a = '0;
    logic [WIDTH-1:0] op_b = '0;
    logic             carry_in = 1'b0;
    logic [WIDTH-1:0] sum_o;
    logic             carry_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lookahead_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) dut_i (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_o     (sum_o),
        .carry_out (carry_out)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: ends a hung run as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fails  = n_fails + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: run exceeded cycle limit");
            finish_run();
        end
    end

    // Apply one vector, then compare sum and carry-out at the falling edge
    task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic ci, input string tag);
        logic [WIDTH:0] exp;
        @(posedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = ci;
        exp = {1'b0, a} + {1'b0, b} + (WIDTH+1)'(ci);
        @(negedge clk);
        n_checks++;
        if (sum_o !== exp[WIDTH-1:0]) begin
            n_fails++;
            $display("FAIL %s sum a=%h b=%h ci=%b: got %h expected %h",
                     tag, a, b, ci, sum_o, exp[WIDTH-1:0]);
        end
        n_checks++;
        if (carry_out !== exp[WIDTH]) begin
            n_fails++;
            $display("FAIL %s carry_out a=%h b=%h ci=%b: got %b expected %b",
                     tag, a, b, ci, carry_out, exp[WIDTH]);
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [WIDTH-1:0] ones;
        ones = '1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: zero inputs give a zero result (R5)
        @(negedge clk);
        n_checks++;
        if (sum_o !== '0 || carry_out !== 1'b0) begin
            n_fails++;
            $display("FAIL R5 reset state: got %h/%b expected 0000/0", sum_o, carry_out);
        end

        // R5: zero and all-ones corners
        apply('0, '0, 1'b0, "R5");
        apply('0, '0, 1'b1, "R5");
        apply(ones, ones, 1'b1, "R5");
        apply(ones, ones, 1'b0, "R1");

        // R3: full propagate chain across all groups
        apply(16'hFFFF, 16'h0000, 1'b1, "R3");
        apply(16'h0000, 16'hFFFF, 1'b1, "R3");
        apply(16'hA5A5, 16'h5A5A, 1'b1, "R3");
        apply(16'hA5A5, 16'h5A5A, 1'b0, "R3");

        // R4: generate in bit 0, propagate above
        apply(16'hAAAB, 16'h5555, 1'b0, "R4");
        apply(16'hFFFF, 16'h0001, 1'b0, "R4");

        // R6/R7/R8: every slice pair of every group. Lower bits carry ci into
        // the slice; upper bits propagate the slice carry to carry_out.
        for (int k = 0; k < NG; k++) begin
            for (int sa = 0; sa < 16; sa++) begin
                for (int sb = 0; sb < 16; sb++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        logic [WIDTH-1:0] a;
                        logic [WIDTH-1:0] b;
                        logic [WIDTH-1:0] lowmask;
                        lowmask = (WIDTH'(1) << (k*GROUP)) - WIDTH'(1);
                        a = ~(WIDTH'(16'hF) << (k*GROUP));
                        a = a | (WIDTH'(sa) << (k*GROUP));
                        b = WIDTH'(sb) << (k*GROUP);
                        if ((sa + sb) == 15 && ci == 1)
                            apply(a, b, 1'(ci), "R8");
                        else if (ci == 0)
                            apply(a & ~lowmask | (ones & lowmask & 16'h0), b, 1'b0, "R7");
                        else
                            apply(a, b, 1'(ci), "R6");
                    end
                end
            end
        end

        // R1/R2: pseudo-random operands
        lfsr = 32'h1F2E_3D4C;
        for (int n = 0; n < 8000; n++) begin
            logic [WIDTH-1:0] a;
            logic [WIDTH-1:0] b;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            a = lfsr[WIDTH-1:0];
            b = lfsr[31:32-WIDTH];
            apply(a, b, lfsr[7], (n % 2 == 0) ? "R1" : "R2");
        end

        finish_run();
    end

endmodule